// File: doc/BRIEF.md
# Four-Lane Alignment-Character Deskew Buffer

This block sits after four per-lane word aligners that share one clock. Each lane delivers one decoded code group per cycle: an 8-bit byte and a control flag. Each lane also has a sync-status bit. Skew in the medium and in clock recovery can make the lanes arrive a few code groups apart. The transmitter sends an alignment control character on every lane in the same cycle during the inter-packet gap. The block uses that character as a common time marker.

Each lane has a small FIFO. A lane ignores everything it receives before its first alignment character. From that character on, it writes every word, while all read pointers stay frozen. The window check passes when the last lane's first alignment character comes no more than `WINDOW` cycles after the first lane's. The block then releases all read pointers in the same cycle, so the four outputs carry time-aligned words and the aligned flag goes high. A failed window, a loss of sync on any lane, or a FIFO at empty or full while aligned clears the block. It then waits for the next alignment character.

The controller has four states. `ST_WAIT_SYNC` waits for sync on all lanes. `ST_WAIT_ALIGN` waits for any lane's first alignment character. `ST_COLLECT` counts the window while the other lanes catch up. `ST_ALIGNED` streams data. The transitions are:

- `ST_WAIT_SYNC`→`ST_WAIT_ALIGN` when all sync bits are high.
- `ST_WAIT_ALIGN`→`ST_COLLECT` on the first alignment character in only some lanes.
- `ST_WAIT_ALIGN`→`ST_ALIGNED` when all lanes see the character together.
- `ST_COLLECT`→`ST_ALIGNED` when the last lane arrives within the window.
- `ST_COLLECT`→`ST_WAIT_ALIGN` when the window expires.
- `ST_ALIGNED`→`ST_WAIT_ALIGN` on a FIFO empty or full fault.
- Any state other than `ST_WAIT_SYNC` goes to `ST_WAIT_SYNC` when a sync bit drops.

Top module: `lane_deskew`

## Requirements
- R1: While not aligned, and out of reset, `aligned` is 0, every `out_valid` bit is 0, and every lane outputs the idle word: byte 0xBC with `out_ctl` = 1.
- R2: The block never aligns unless the sync bits of all four lanes are high. With one sync bit held low, alignment characters on every lane leave `aligned` at 0.
- R3: The alignment character is byte 0x7C with the control flag set. Words that arrive on a lane before its first alignment character are discarded. The first word released on every lane is 0x7C with `out_ctl` = 1.
- R4: After a lane's first alignment character, each incoming word is buffered. Once released, each lane outputs consecutive input words with no gap or repeat, one per cycle.
- R5: Suppose the last lane's first alignment character arrives k ≤ 10 cycles after the first lane's. Then `aligned` and all four `out_valid` bits rise together, visible right after the clock edge that captures the last lane's alignment character.
- R6: If the spread of first arrivals exceeds 10 cycles, the block does not align on that set of characters.
- R7: After a window failure the block re-arms. A later set of alignment characters whose spread is within the window aligns it, with the first released word being that later character.
- R8: If any sync bit is low at a clock edge while aligned, `aligned` and `out_valid` go low after that edge and the outputs return to idle.
- R9: After sync returns, the block realigns only on the next alignment character, and it releases that character first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common lane clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 4 | Per-lane sync status from the word aligners |
| lane_data | input | 32 | Per-lane byte, lane i at bits [8i+7:8i] |
| lane_ctl | input | 4 | Per-lane control flag |
| out_data | output | 32 | Deskewed bytes, lane i at bits [8i+7:8i] |
| out_ctl | output | 4 | Deskewed control flags |
| out_valid | output | 4 | Per-lane output valid |
| aligned | output | 1 | Lanes are deskewed and streaming |

## Verification
The checker watches four properties on every cycle:
- the idle word and low valids whenever `aligned` is low;
- that `aligned` only rises after a cycle with all sync bits high;
- that the first released word on each lane is the alignment character;
- that the valid bits stay in lockstep, and that a sync loss drops alignment on the next edge.

Some behaviour is only visible in the bench's scenarios:
- the timing of the release against each skew pattern;
- the exact window boundary at 10 versus 11 cycles;
- that released streams are contiguous;
- re-arming after a failed window or a sync loss.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
    localparam int          CG_W    = 8;
    localparam logic [7:0]  K_ALIGN = 8'h7C;
    localparam logic [7:0]  K_IDLE  = 8'hBC;

    typedef enum logic [1:0] {
        ST_WAIT_SYNC,
        ST_WAIT_ALIGN,
        ST_COLLECT,
        ST_ALIGNED
    } dsk_state_e;

    typedef struct packed {
        logic       ctl;
        logic [7:0] byt;
    } cg_t;
endpackage

// File: rtl/deskew_lane_buf.sv
module deskew_lane_buf
    import deskew_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     wr_en,
    input  cg_t                      wr_cg,
    input  logic                     rd_en,
    output cg_t                      rd_cg,
    output logic [$clog2(DEPTH):0]   level
);
    localparam int PTR_W = $clog2(DEPTH);

    cg_t             mem [DEPTH];
    logic [PTR_W:0]  wr_ptr;
    logic [PTR_W:0]  rd_ptr;

    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            mem[wr_ptr[PTR_W-1:0]] <= wr_cg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assign rd_cg = mem[rd_ptr[PTR_W-1:0]];
    assign level = wr_ptr - rd_ptr;
endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl
    import deskew_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int WINDOW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_all,
    input  logic [LANES-1:0]  hit,
    input  logic              fault,
    output dsk_state_e        state,
    output logic [LANES-1:0]  wr_en,
    output logic              rd_en,
    output logic              clr
);
    localparam int CNT_W = $clog2(WINDOW + 1);

    dsk_state_e        state_nx;
    logic [LANES-1:0]  seen, seen_nx, seen_or;
    logic [CNT_W-1:0]  cnt, cnt_nx;

    assign seen_or = seen | hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT_SYNC;
            seen  <= '0;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            seen  <= seen_nx;
            cnt   <= cnt_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        seen_nx  = seen;
        cnt_nx   = cnt;
        unique case (state)
            ST_WAIT_SYNC: begin
                if (sync_all) state_nx = ST_WAIT_ALIGN;
            end
            ST_WAIT_ALIGN: begin
                if (!sync_all) begin
                    state_nx = ST_WAIT_SYNC;
                end else if (&seen_or) begin
                    state_nx = ST_ALIGNED;
                    seen_nx  = seen_or;
                end else if (|hit) begin
                    state_nx = ST_COLLECT;
                    seen_nx  = seen_or;
                    cnt_nx   = CNT_W'(1);
                end
            end
            ST_COLLECT: begin
                if (!sync_all) begin
                    state_nx = ST_WAIT_SYNC;
                end else if (&seen_or) begin
                    state_nx = ST_ALIGNED;
                    seen_nx  = seen_or;
                end else if (cnt == CNT_W'(WINDOW)) begin
                    state_nx = ST_WAIT_ALIGN;
                end else begin
                    seen_nx  = seen_or;
                    cnt_nx   = cnt + 1'b1;
                end
            end
            ST_ALIGNED: begin
                if (!sync_all) state_nx = ST_WAIT_SYNC;
                else if (fault) state_nx = ST_WAIT_ALIGN;
            end
        endcase
        clr = (state_nx == ST_WAIT_SYNC) || (state_nx == ST_WAIT_ALIGN);
        if (clr) begin
            seen_nx = '0;
            cnt_nx  = '0;
        end
    end

    // outputs
    always_comb begin
        wr_en = '0;
        rd_en = 1'b0;
        if (state != ST_WAIT_SYNC && sync_all && !clr) begin
            wr_en = seen_or;
        end
        if (state == ST_ALIGNED && !clr) begin
            rd_en = 1'b1;
        end
    end
endmodule

// File: rtl/lane_deskew.sv
module lane_deskew
    import deskew_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int DEPTH  = 16,
    parameter int WINDOW = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LANES-1:0]      sync_in,
    input  logic [LANES*CG_W-1:0] lane_data,
    input  logic [LANES-1:0]      lane_ctl,
    output logic [LANES*CG_W-1:0] out_data,
    output logic [LANES-1:0]      out_ctl,
    output logic [LANES-1:0]      out_valid,
    output logic                  aligned
);
    localparam int LVL_W = $clog2(DEPTH) + 1;

    dsk_state_e        state;
    logic [LANES-1:0]  hit, wr_en, lane_bad;
    logic              rd_en, clr, fault;

    deskew_ctrl #(.LANES(LANES), .WINDOW(WINDOW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_all (&sync_in),
        .hit      (hit),
        .fault    (fault),
        .state    (state),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .clr      (clr)
    );

    assign aligned = (state == ST_ALIGNED);
    assign fault   = |lane_bad;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        cg_t              in_cg, rd_cg;
        logic [LVL_W-1:0] level;

        assign in_cg  = '{ctl: lane_ctl[i], byt: lane_data[i*CG_W +: CG_W]};
        assign hit[i] = in_cg.ctl && (in_cg.byt == K_ALIGN);
        // headroom guard: nothing left to read, or no room for the next write
        assign lane_bad[i] = (level == '0) || (level == LVL_W'(DEPTH));

        deskew_lane_buf #(.DEPTH(DEPTH)) u_buf (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .wr_en (wr_en[i]),
            .wr_cg (in_cg),
            .rd_en (rd_en),
            .rd_cg (rd_cg),
            .level (level)
        );

        assign out_data[i*CG_W +: CG_W] = aligned ? rd_cg.byt : K_IDLE;
        assign out_ctl[i]               = aligned ? rd_cg.ctl : 1'b1;
        assign out_valid[i]             = aligned;
    end
endmodule

// File: rtl/lane_deskew_chk.sv
module lane_deskew_chk
    import deskew_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [LANES-1:0]      sync_in,
    input logic [LANES*CG_W-1:0] out_data,
    input logic [LANES-1:0]      out_ctl,
    input logic [LANES-1:0]      out_valid,
    input logic                  aligned
);
    a_r1_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
        !aligned |-> (out_valid == '0 && out_ctl == '1 && out_data == {LANES{K_IDLE}}));

    a_r2_sync_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned) |-> $past(&sync_in));

    a_r3_first_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned) |-> (out_ctl == '1 && out_data == {LANES{K_ALIGN}}));

    a_r5_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        aligned |-> (out_valid == '1));

    a_r8_sync_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned && !(&sync_in)) |=> (!aligned && out_valid == '0));
endmodule

bind lane_deskew lane_deskew_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_in   (sync_in),
    .out_data  (out_data),
    .out_ctl   (out_ctl),
    .out_valid (out_valid),
    .aligned   (aligned)
);

// File: tb/lane_deskew_tb.sv
`timescale 1ns/1ps
module lane_deskew_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  sync_in = '0;
    logic [31:0] lane_data = '0;
    logic [3:0]  lane_ctl = '0;
    logic [31:0] out_data;
    logic [3:0]  out_ctl;
    logic [3:0]  out_valid;
    logic        aligned;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    lane_deskew u_dut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
        .lane_data(lane_data), .lane_ctl(lane_ctl),
        .out_data(out_data), .out_ctl(out_ctl),
        .out_valid(out_valid), .aligned(aligned)
    );

    // {second-set skews, first-set skews}; lane i skew in nibble i
    localparam logic [31:0] VEC [7] = '{
        {16'h0000, 16'h0000},
        {16'h3210, 16'h3210},
        {16'h1203, 16'h1203},
        {16'h25A0, 16'h25A0},
        {16'h0000, 16'h33B0},
        {16'h4444, 16'h4444},
        {16'h2010, 16'h000C}
    };

    // transmitted symbol n: alignment at 8 and 40, idle before 0, data else
    function automatic logic [8:0] sym(int n);
        if (n == 8 || n == 40) return {1'b1, 8'h7C};
        if (n < 0)             return {1'b1, 8'hBC};
        return {1'b0, 8'(n * 29 + 3)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic drive(int c, logic [15:0] sk, logic [3:0] sy);
        for (int i = 0; i < 4; i++) begin
            logic [8:0] s;
            s = sym(c - int'(sk[i*4 +: 4]));
            lane_ctl[i]        = s[8];
            lane_data[i*8 +: 8] = s[7:0];
        end
        sync_in = sy;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        sync_in = '0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic check_lanes(string req, int idx);
        for (int i = 0; i < 4; i++) begin
            check(req, {23'd0, out_ctl[i], out_data[i*8 +: 8]}, {23'd0, sym(idx)});
        end
        check(req, {28'd0, out_valid}, 32'hF);
    endtask

    task automatic run_vec(logic [15:0] ska, logic [15:0] skb);
        int mn_a = 99, mx_a = 0, mx_b = 0;
        int exp_rise, exp_idx, rise_c;
        bit pass_a, prev;
        for (int i = 0; i < 4; i++) begin
            int a = int'(ska[i*4 +: 4]);
            int b = int'(skb[i*4 +: 4]);
            if (a < mn_a) mn_a = a;
            if (a > mx_a) mx_a = a;
            if (b > mx_b) mx_b = b;
        end
        pass_a   = (mx_a - mn_a) <= 10;
        exp_idx  = pass_a ? 8 : 40;
        exp_rise = pass_a ? 8 + mx_a : 40 + mx_b;
        rise_c   = -100;
        prev     = 1'b0;
        do_reset();
        for (int c = -4; c <= 60; c++) begin
            drive(c, (c < 30) ? ska : skb, 4'hF);
            if (aligned && !prev && rise_c == -100) rise_c = c;
            if (rise_c != -100 && c - rise_c < 8)
                check_lanes((c == rise_c) ? "R3" : "R4", exp_idx + c - rise_c);
            if (!pass_a && c == 38) check("R6", {31'd0, aligned}, 32'd0);
            prev = aligned;
        end
        check(pass_a ? "R5" : "R7", rise_c, exp_rise);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R5 act=timeout exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        check("R1", {31'd0, aligned}, 32'd0);
        check("R1", {28'd0, out_valid}, 32'd0);
        check("R1", out_data, 32'hBCBCBCBC);
        check("R1", {28'd0, out_ctl}, 32'hF);

        // table of skew patterns
        for (int v = 0; v < 7; v++) begin
            run_vec(VEC[v][15:0], VEC[v][31:16]);
        end

        // R2: one lane out of sync, alignment characters must be ignored
        begin
            int seen_hi = 0;
            do_reset();
            for (int c = -4; c <= 50; c++) begin
                drive(c, 16'h0000, 4'b1011);
                if (aligned || out_valid != 4'd0) seen_hi++;
            end
            check("R2", seen_hi, 0);
        end

        // R8 / R9: sync loss while aligned, then realignment
        begin
            int rise_c = -100;
            bit prev = 1'b0;
            do_reset();
            for (int c = -4; c <= 50; c++) begin
                drive(c, 16'h0000, (c == 20 || c == 21) ? 4'b0111 : 4'hF);
                if (c == 19) check("R8", {31'd0, aligned}, 32'd1);
                if (c == 20) begin
                    check("R8", {31'd0, aligned}, 32'd0);
                    check("R8", {28'd0, out_valid}, 32'd0);
                    check("R8", out_data, 32'hBCBCBCBC);
                end
                if (c > 21 && aligned && !prev && rise_c == -100) begin
                    rise_c = c;
                    check_lanes("R9", 40);
                end
                prev = aligned;
            end
            check("R9", rise_c, 40);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule